// File: doc/BRIEF.md
# ARINC 429 Word Receiver

This block takes a serial ARINC 429 word stream, already reduced to two digital
level signals (one that is high while the line carries a "one" level and one
that is high while it carries a "zero" level), and delivers each word as two
16-bit halves on a parallel bus. A bit latch takes exactly one bit per
return-to-null cycle. The bits shift into an input register with the least
significant bit first. The end of a word is found by counting ticks of a
separate gap clock while the line is null.

When a word closes, the block checks that exactly 32 bits arrived. It can also
check odd parity. The word then moves into a 32-bit receive buffer, a data-ready
flag rises, and an error flag shows the result of the checks. A host reads the
buffer with two active-low read strobes, low half first. The next word can
arrive while the host is still reading the previous one.

All inputs are synchronous to `clk`. The gap clock arrives as `gap_tick`, a
one-cycle enable pulse on `clk`.

Top module: `a429_word_rx`

## Requirements
- R1: After reset `data_ready`, `word_err` and `bus_oe` are low and the receive buffer holds zero.
- R2: Bits are stored least significant first. The first bit received becomes bit 0 of the buffer. The first read returns buffer bits 15..0.
- R3: A valid level (exactly one of `line_one`, `line_zero` high) adds one bit, however many clock cycles it lasts. Another bit is taken only after a null level (neither input high, or both high).
- R4: A word closes only when `gap_tick` has pulsed 16 times while the line is null. After 15 ticks, `data_ready` is still low.
- R5: `data_ready` rises in the cycle after the word closes. It falls only when a read strobe is asserted while the low half is selected.
- R6: The half select toggles each time `rd_n` is released. A second read therefore returns buffer bits 31..16. The select returns to the low half whenever a new word is buffered.
- R7: While `rd_n` is low, `bus_oe` is high and `bus_data` carries the selected half. While `rd_n` is high, `bus_oe` is low and `bus_data` is zero.
- R8: When `par_en` is high, buffer bit 31 is replaced by the parity error bit. That bit is 1 when the 32 received bits hold an even number of ones. `word_err` is raised in that case.
- R9: When `par_en` is low, bit 31 is stored unchanged and parity does not affect `word_err`.
- R10: `word_err` is raised when a word closes with fewer or more than 32 bits.
- R11: Any valid level clears the gap count. A pause of 15 ticks inside a word therefore does not close it.
- R12: A read while `data_ready` is low still drives the current buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_one | input | 1 | Line is at the "one" level |
| line_zero | input | 1 | Line is at the "zero" level |
| gap_tick | input | 1 | One-cycle pulse per gap clock period |
| par_en | input | 1 | Enables the odd parity check |
| rd_n | input | 1 | Active-low read strobe |
| bus_data | output | 16 | Selected buffer half while reading |
| bus_oe | output | 1 | Bus drive enable (tri-state control) |
| data_ready | output | 1 | A new word is in the buffer |
| word_err | output | 1 | Bit-count or parity error in the last word |

## Verification
Assertions check, on every cycle, the following:
- A held level never advances the bit count.
- The bit count never passes its saturation point.
- A word is buffered only at the end of a full gap count.
- `data_ready` falls only during a read strobe.
- The bus is quiet whenever the strobe is released.

Only the bench scenarios can show the following:
- Bit order and the values of the two halves.
- Parity substitution in bit 31 and the resulting error flag.
- Detection of short and long words.
- Survival of a mid-word pause of 15 ticks.
- Re-reading a buffer that has already been read.

// File: rtl/a429_word_rx.sv
module a429_word_rx #(
  parameter int HALF_W    = 16,
  parameter int GAP_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_one,
  input  logic              line_zero,
  input  logic              gap_tick,
  input  logic              par_en,
  input  logic              rd_n,
  output logic [HALF_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              data_ready,
  output logic              word_err
);
  localparam int W  = 2 * HALF_W;
  localparam int CW = $clog2(W + 2);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_SAT  = CW'(W + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

  logic [W-1:0]  shreg, rxbuf;
  logic [CW-1:0] bit_cnt;
  logic [GW-1:0] gap_cnt;
  logic          latched, half, rd_q;

  wire valid   = line_one ^ line_zero;
  wire take    = valid & ~latched;
  wire in_word = bit_cnt != '0;
  wire close   = in_word & ~valid & gap_tick & (gap_cnt == GAP_LAST);
  wire odd_ok  = ^shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      rxbuf      <= '0;
      bit_cnt    <= '0;
      gap_cnt    <= '0;
      latched    <= 1'b0;
      half       <= 1'b0;
      rd_q       <= 1'b1;
      data_ready <= 1'b0;
      word_err   <= 1'b0;
    end else begin
      latched <= valid;
      rd_q    <= rd_n;
      if (!rd_n && !half) data_ready <= 1'b0;
      if (rd_n && !rd_q) half <= ~half;
      if (valid) gap_cnt <= '0;
      else if (close) gap_cnt <= '0;
      else if (in_word && gap_tick) gap_cnt <= gap_cnt + 1'b1;
      if (take) begin
        shreg <= {line_one, shreg[W-1:1]};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end else if (close) begin
        rxbuf      <= par_en ? {~odd_ok, shreg[W-2:0]} : shreg;
        word_err   <= (bit_cnt != CNT_FULL) | (par_en & ~odd_ok);
        data_ready <= 1'b1;
        half       <= 1'b0;
        bit_cnt    <= '0;
        shreg      <= '0;
      end
    end
  end

  assign bus_oe   = ~rd_n;
  assign bus_data = rd_n ? '0 : (half ? rxbuf[W-1:HALF_W] : rxbuf[HALF_W-1:0]);

  a_r3_one_bit_per_level: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && valid) |=> $stable(bit_cnt));
  a_r10_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT);
  a_r4_close_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> ($past(gap_cnt) == GAP_LAST && $past(gap_tick) && !$past(valid)));
  a_r5_ready_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(!rd_n));
  a_r7_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (!bus_oe && bus_data == '0));
endmodule

// File: tb/a429_word_rx_tb.sv
module a429_word_rx_tb_top;
  logic clk = 0, rst_n = 0;
  logic line_one = 0, line_zero = 0, gap_tick = 0, par_en = 0, rd_n = 1;
  logic [15:0] bus_data;
  logic bus_oe, data_ready, word_err;
  int checks = 0, failures = 0;
  logic [15:0] lo, hi;

  always #4 clk = ~clk;

  a429_word_rx dut_i (.clk, .rst_n, .line_one, .line_zero, .gap_tick, .par_en,
    .rd_n, .bus_data, .bus_oe, .data_ready, .word_err);

  function automatic logic [31:0] exp_buf(logic [31:0] w, logic pe);
    return pe ? {~(^w), w[30:0]} : w;
  endfunction
  function automatic logic exp_err(logic [31:0] w, logic pe);
    return pe & ~(^w);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b, int hold);
    line_one = b; line_zero = ~b; cyc(hold);
    line_one = 0; line_zero = 0; cyc(2);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      gap_tick = 1; cyc(1); gap_tick = 0; cyc(1);
    end
  endtask

  task automatic send_bits(logic [39:0] w, int n, int hold);
    for (int i = 0; i < n; i++) send_bit(w[i], hold);
  endtask

  task automatic read_both();
    rd_n = 0; cyc(1);
    lo = bus_data;
    chk("R7 oe during read", {31'b0, bus_oe}, 1);
    chk("R5 ready cleared by first read", {31'b0, data_ready}, 0);
    rd_n = 1; cyc(2);
    rd_n = 0; cyc(1); hi = bus_data;
    rd_n = 1; cyc(2);
  endtask

  task automatic word_check(logic [31:0] w, logic pe, int hold, string tag);
    par_en = pe;
    send_bits({8'h0, w}, 32, hold);
    ticks(16);
    chk({tag, " ready"}, {31'b0, data_ready}, 1);
    chk({tag, " err"}, {31'b0, word_err}, {31'b0, exp_err(w, pe)});
    read_both();
    chk({tag, " data"}, {hi, lo}, exp_buf(w, pe));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd4242));
    cyc(3);
    // R1: reset state
    chk("R1 ready", {31'b0, data_ready}, 0);
    chk("R1 err", {31'b0, word_err}, 0);
    chk("R7 quiet oe", {31'b0, bus_oe}, 0);
    chk("R7 quiet data", {16'b0, bus_data}, 0);
    rst_n = 1; cyc(2);
    rd_n = 0; cyc(1);
    chk("R1 buffer zero", {16'b0, bus_data}, 0);
    rd_n = 1; cyc(2);
    rd_n = 0; cyc(1); rd_n = 1; cyc(2);

    // R2 / R9: directed word, parity off
    word_check(32'h8000_0001, 0, 2, "R2 R9 lsb first");
    // R8: parity on, odd word -> no error, bit31 = 0
    word_check(32'h0000_0007, 1, 2, "R8 odd parity");
    // R8: parity on, even word -> error, bit31 = 1
    word_check(32'h0000_0003, 1, 2, "R8 even parity");
    // R3: long held levels
    word_check(32'hA5C3_3C5A, 0, 6, "R3 held level");

    // R12: reread after data_ready low returns low half again
    rd_n = 0; cyc(1);
    chk("R12 reread low half", {16'b0, bus_data}, 32'h3C5A);
    rd_n = 1; cyc(2);
    rd_n = 0; cyc(1); rd_n = 1; cyc(2);

    // R4: 15 ticks do not close, 16th does
    w = 32'h1234_5678; par_en = 0;
    send_bits({8'h0, w}, 32, 2);
    ticks(15);
    chk("R4 no close after 15", {31'b0, data_ready}, 0);
    ticks(1);
    chk("R4 close after 16", {31'b0, data_ready}, 1);
    // R6: new word while half select is high returns select to low
    rd_n = 0; cyc(1); rd_n = 1; cyc(2);
    send_bits({8'h0, 32'hCAFE_BEEF}, 32, 2);
    ticks(16);
    rd_n = 0; cyc(1);
    chk("R6 low half after new word", {16'b0, bus_data}, 32'hBEEF);
    rd_n = 1; cyc(2);
    rd_n = 0; cyc(1);
    chk("R6 high half second read", {16'b0, bus_data}, 32'hCAFE);
    rd_n = 1; cyc(2);

    // R11: mid-word pause of 15 ticks
    w = 32'h0F0F_F0F0;
    send_bits({8'h0, w}, 10, 2);
    ticks(15);
    send_bits({8'h0, w >> 10}, 22, 2);
    ticks(16);
    chk("R11 pause err", {31'b0, word_err}, 0);
    read_both();
    chk("R11 pause data", {hi, lo}, w);

    // R10: short and long words
    send_bits(40'h0, 31, 2); ticks(16);
    chk("R10 short err", {31'b0, word_err}, 1);
    read_both();
    send_bits(40'hFF_FFFF_FFFF, 33, 2); ticks(16);
    chk("R10 long err", {31'b0, word_err}, 1);
    read_both();

    // random words
    for (int k = 0; k < 20; k++) begin
      w = $urandom;
      word_check(w, 1'($urandom), 2 + int'($urandom % 3), "R2 R8 R9 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule